// File: doc/BRIEF.md
# PLL Lock Indicator Qualifier

This block turns a raw, per-cycle "loop is locked" condition into a registered lock flag for a PLL. The raw condition is a digital input. A strobe marks each phase-detector compare cycle. A static mode input picks one of two policies. In immediate mode, the flag rises on the first compare strobe that sees the raw condition high. In qualified mode, the raw condition must hold across a programmed run of consecutive compare strobes before the flag rises.

In qualified mode the length of the run comes from a 4-bit code. The run is a multiple of 16 strobes, from 16 up to 256. In both modes the flag falls on the clock edge after any cycle in which the raw condition is low. If the mode or the code changes while running, the flag drops and qualification starts again from zero. The analog loop parts (phase detector, charge pump, filter, oscillator) are outside this block.

Top module: `lock_qualifier`

## Requirements
- R1: While `rst_n` is low, and on release until a strobe qualifies, `lock_out` is 0. Reset is asserted asynchronously and released through a two-stage synchronizer.
- R2: With `freq_mode` = 0 (immediate mode), `lock_out` is 1 after the clock edge that samples `strobe` = 1 with `raw_lock` = 1.
- R3: With `freq_mode` = 1 (qualified mode), `lock_out` rises on the edge that samples the N-th consecutive strobe with `raw_lock` high, where N = 16 × (`qual_code` + 1). `lock_out` stays 0 through strobe N-1.
- R4: The code range ends are exact: `qual_code` = 0 gives 16 strobes and `qual_code` = 15 gives 256 strobes.
- R5: Any cycle with `raw_lock` low clears the consecutive-strobe count, whether or not a strobe is present. The next qualification counts from zero.
- R6: In either mode, a cycle with `raw_lock` low makes `lock_out` 0 after the next clock edge.
- R7: Once qualified, further strobes with `raw_lock` high keep `lock_out` at 1 indefinitely. The count saturates and does not wrap, including past 256 strobes.
- R8: A change of `freq_mode` or `qual_code` from one cycle to the next makes `lock_out` 0 after the next edge and restarts qualification from zero.
- R9: `lock_out` never rises on an edge that did not sample `strobe` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_lock | input | 1 | Raw lock condition from the loop, valid every cycle |
| strobe | input | 1 | One-cycle pulse per phase-detector compare cycle |
| freq_mode | input | 1 | 0 = immediate mode, 1 = qualified mode |
| qual_code | input | 4 | Qualification length code k, run = 16 × (k + 1) strobes |
| lock_out | output | 1 | Registered lock flag |

## Verification
A count that is off by one in either direction shows at `lock_out` as a rise one strobe early or one strobe late. The bench probes this directly at both ends of the code range. A count that is not cleared on a raw-lock drop, or on a configuration change, shows on the next qualification as a premature rise. That rise can come many strobes before the expected one, so the bench requalifies right after each such event. A counter that wraps instead of saturating shows as a spurious drop of `lock_out` once the run exceeds 256 strobes, so one directed run is held well past that length.

// File: rtl/lockq_pkg.sv
package lockq_pkg;
  typedef enum logic {
    LQ_IMMEDIATE = 1'b0,
    LQ_QUALIFIED = 1'b1
  } lq_mode_e;

  typedef enum logic [1:0] {
    LQ_ACT_HOLD  = 2'd0,
    LQ_ACT_DROP  = 2'd1,
    LQ_ACT_EVAL  = 2'd2
  } lq_act_e;
endpackage

// File: rtl/lockq_rst_sync.sv
module lockq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_ok_n = sync_q[STAGES-1];
endmodule

// File: rtl/lockq_cfg_watch.sv
module lockq_cfg_watch #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_ok_n,
  input  logic              mode,
  input  logic [CODE_W-1:0] code,
  output logic              cfg_chg
);
  localparam int CFG_W = CODE_W + 1;

  logic [CFG_W-1:0] cfg_now;
  logic [CFG_W-1:0] cfg_q;
  logic             cfg_vld_q;

  assign cfg_now = {mode, code};

  // First active cycle only captures; later cycles compare against it
  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      cfg_q     <= '0;
      cfg_vld_q <= 1'b0;
    end else begin
      cfg_q     <= cfg_now;
      cfg_vld_q <= 1'b1;
    end
  end

  assign cfg_chg = cfg_vld_q && (cfg_now != cfg_q);
endmodule

// File: rtl/lockq_run_cnt.sv
module lockq_run_cnt #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_ok_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [CNT_W-1:0] target,
  output logic [CNT_W-1:0] cnt,
  output logic             hit_d
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clr) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (adv && (cnt_q < target)) begin
      cnt_d  = cnt_q + CNT_W'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign hit_d = !clr && (cnt_d >= target);
  assign cnt   = cnt_q;
endmodule

// File: rtl/lock_qualifier.sv
module lock_qualifier #(
  parameter int CODE_W = 4,
  parameter int STEP   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raw_lock,
  input  logic              strobe,
  input  logic              freq_mode,
  input  logic [CODE_W-1:0] qual_code,
  output logic              lock_out
);
  import lockq_pkg::*;

  localparam int MAX_RUN = STEP << CODE_W;
  localparam int CNT_W   = $clog2(MAX_RUN) + 1;

  logic             rst_ok_n;
  logic             cfg_chg;
  logic [CNT_W-1:0] qual_tgt;
  logic [CNT_W-1:0] run_cnt;
  logic             run_hit_d;
  logic             cnt_clr;
  logic             cnt_adv;
  lq_mode_e         mode;
  lq_act_e          act;
  logic             lock_q;
  logic             lock_d;
  logic             lock_en;

  assign mode     = lq_mode_e'(freq_mode);
  assign qual_tgt = (CNT_W'(qual_code) + CNT_W'(1)) * CNT_W'(STEP);

  lockq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_ok_n (rst_ok_n)
  );

  lockq_cfg_watch #(.CODE_W(CODE_W)) u_cfg (
    .clk      (clk),
    .rst_ok_n (rst_ok_n),
    .mode     (freq_mode),
    .code     (qual_code),
    .cfg_chg  (cfg_chg)
  );

  assign cnt_clr = cfg_chg || !raw_lock || (mode == LQ_IMMEDIATE);
  assign cnt_adv = strobe && raw_lock && (mode == LQ_QUALIFIED);

  lockq_run_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_ok_n (rst_ok_n),
    .clr      (cnt_clr),
    .adv      (cnt_adv),
    .target   (qual_tgt),
    .cnt      (run_cnt),
    .hit_d    (run_hit_d)
  );

  // Decide what the flag does this cycle
  always_comb begin
    if (cfg_chg || !raw_lock) begin
      act = LQ_ACT_DROP;
    end else if (strobe) begin
      act = LQ_ACT_EVAL;
    end else begin
      act = LQ_ACT_HOLD;
    end
  end

  always_comb begin
    lock_d  = lock_q;
    lock_en = 1'b0;
    unique case (act)
      LQ_ACT_DROP: begin
        lock_d  = 1'b0;
        lock_en = 1'b1;
      end
      LQ_ACT_EVAL: begin
        lock_d  = (mode == LQ_IMMEDIATE) ? 1'b1 : run_hit_d;
        lock_en = 1'b1;
      end
      default: begin
        lock_d  = lock_q;
        lock_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      lock_q <= 1'b0;
    end else if (lock_en) begin
      lock_q <= lock_d;
    end
  end

  assign lock_out = lock_q;
endmodule

// File: rtl/lockq_chk.sv
module lockq_chk #(
  parameter int CODE_W = 4,
  parameter int CNT_W  = 9
) (
  input logic              clk,
  input logic              rst_ok_n,
  input logic              raw_lock,
  input logic              strobe,
  input logic              freq_mode,
  input logic [CODE_W-1:0] qual_code,
  input logic              lock_out,
  input logic [CNT_W-1:0]  run_cnt,
  input logic [CNT_W-1:0]  qual_tgt
);
  // R2
  imm_rise_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!freq_mode && strobe && raw_lock && $stable(freq_mode) && $stable(qual_code))
      |=> lock_out);

  // R3
  qual_len_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ($rose(lock_out) && $past(freq_mode)) |-> (run_cnt == $past(qual_tgt)));

  // R6
  loss_drop_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !raw_lock |=> !lock_out);

  // R5
  loss_clear_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !raw_lock |=> (run_cnt == '0));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    $stable(qual_code) |-> (run_cnt <= qual_tgt));

  // R8
  cfg_drop_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    ($past(rst_ok_n) && !($stable(freq_mode) && $stable(qual_code))) |=> !lock_out);

  // R9
  strobe_only_chk: assert property (@(posedge clk) disable iff (!rst_ok_n)
    $rose(lock_out) |-> $past(strobe));
endmodule

bind lock_qualifier lockq_chk #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_ok_n  (rst_ok_n),
  .raw_lock  (raw_lock),
  .strobe    (strobe),
  .freq_mode (freq_mode),
  .qual_code (qual_code),
  .lock_out  (lock_out),
  .run_cnt   (run_cnt),
  .qual_tgt  (qual_tgt)
);

// File: tb/sim_lock_qualifier.sv
`timescale 1ns/1ps
module sim_lock_qualifier;
  logic       clk;
  logic       rst_n;
  logic       raw_lock;
  logic       strobe;
  logic       freq_mode;
  logic [3:0] qual_code;
  logic       lock_out;

  int checks;
  int errors;

  // reference model state
  logic       m_lock;
  int         m_run;
  logic       m_pfm;
  logic [3:0] m_pcode;
  string      m_tag;

  lock_qualifier u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .raw_lock  (raw_lock),
    .strobe    (strobe),
    .freq_mode (freq_mode),
    .qual_code (qual_code),
    .lock_out  (lock_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int run_len(input logic [3:0] k);
    return 16 * (int'(k) + 1);
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: lock_out=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Model update for one clock edge with the current inputs
  task automatic model_edge();
    if ({freq_mode, qual_code} != {m_pfm, m_pcode}) begin
      m_run = 0; m_lock = 1'b0; m_tag = "R8";
    end else if (!raw_lock) begin
      m_run = 0; m_lock = 1'b0; m_tag = "R6";
    end else if (strobe) begin
      if (!freq_mode) begin
        m_run = 0; m_lock = 1'b1; m_tag = "R2";
      end else begin
        if (m_run < run_len(qual_code)) m_run++;
        if (m_run >= run_len(qual_code)) begin
          m_tag = m_lock ? "R7" : "R3";
          m_lock = 1'b1;
        end else begin
          m_tag = "R5";
        end
      end
    end else begin
      if (!freq_mode) m_run = 0;
      m_tag = "R9";
    end
    m_pfm   = freq_mode;
    m_pcode = qual_code;
  endtask

  // Drive after a falling edge, model at rising edge, compare at falling edge
  task automatic step(input logic r, input logic s, input logic fm, input logic [3:0] k);
    raw_lock  = r;
    strobe    = s;
    freq_mode = fm;
    qual_code = k;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(m_tag, lock_out, m_lock);
  endtask

  task automatic strobes(input int n, input logic fm, input logic [3:0] k);
    for (int i = 0; i < n; i++) begin
      step(1'b1, 1'b1, fm, k);
      step(1'b1, 1'b0, fm, k);
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: lock_out=%0b expected=finish", lock_out);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    checks = 0;
    errors = 0;
    seed = int'($urandom(32'd4021));
    rst_n = 1'b0; raw_lock = 1'b1; strobe = 1'b1; freq_mode = 1'b0; qual_code = 4'd0;
    repeat (4) @(negedge clk);
    check("R1 in reset", lock_out, 1'b0);
    rst_n = 1'b1;
    raw_lock = 1'b0; strobe = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 after release", lock_out, 1'b0);
    m_lock = 1'b0; m_run = 0; m_pfm = 1'b0; m_pcode = 4'd0; m_tag = "R1";

    // R9: raw high without strobe does not assert
    step(1'b1, 1'b0, 1'b0, 4'd0);
    step(1'b1, 1'b0, 1'b0, 4'd0);
    check("R9 no strobe", lock_out, 1'b0);
    // R2 immediate
    step(1'b1, 1'b1, 1'b0, 4'd0);
    check("R2 immediate", lock_out, 1'b1);
    // R6 drop in immediate mode without strobe
    step(1'b0, 1'b0, 1'b0, 4'd0);
    check("R6 immediate drop", lock_out, 1'b0);

    // R8 switch to qualified code 0, then R4 low end
    step(1'b1, 1'b0, 1'b1, 4'd0);
    strobes(15, 1'b1, 4'd0);
    check("R4 code0 at 15", lock_out, 1'b0);
    step(1'b1, 1'b1, 1'b1, 4'd0);
    check("R4 code0 at 16", lock_out, 1'b1);
    // R7 hold well past 256 strobes
    strobes(300, 1'b1, 4'd0);
    check("R7 saturate", lock_out, 1'b1);
    // R8 code change drops and restarts
    step(1'b1, 1'b0, 1'b1, 4'd1);
    check("R8 code change", lock_out, 1'b0);
    strobes(31, 1'b1, 4'd1);
    check("R3 code1 at 31", lock_out, 1'b0);
    step(1'b1, 1'b1, 1'b1, 4'd1);
    check("R3 code1 at 32", lock_out, 1'b1);
    // R5 glitch between strobes clears the run
    step(1'b0, 1'b0, 1'b1, 4'd1);
    check("R6 qualified drop", lock_out, 1'b0);
    strobes(20, 1'b1, 4'd1);
    step(1'b0, 1'b0, 1'b1, 4'd1);
    strobes(31, 1'b1, 4'd1);
    check("R5 restart after glitch", lock_out, 1'b0);
    step(1'b1, 1'b1, 1'b1, 4'd1);
    check("R5 requalified", lock_out, 1'b1);
    // R4 high end
    step(1'b1, 1'b0, 1'b1, 4'd15);
    strobes(255, 1'b1, 4'd15);
    check("R4 code15 at 255", lock_out, 1'b0);
    step(1'b1, 1'b1, 1'b1, 4'd15);
    check("R4 code15 at 256", lock_out, 1'b1);
    // R8 mode change while locked
    step(1'b1, 1'b0, 1'b0, 4'd15);
    check("R8 mode change", lock_out, 1'b0);

    // Random phase: mostly short codes, rare drops and config changes
    begin
      logic fm;
      logic [3:0] k;
      fm = 1'b1; k = 4'd0;
      for (int i = 0; i < 40000; i++) begin
        if (($urandom % 2000) == 0) fm = ~fm;
        if (($urandom % 1500) == 0) k = 4'($urandom % 3);
        step(($urandom % 80) != 0, ($urandom % 3) == 0, fm, k);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule